// File: doc/BRIEF.md
# Modem Handshake Control and Status Logic

This block holds the modem control register and the modem status register of a UART-style communications element and drives its handshake pins. The control register bits drive three active-low outputs: request-to-send and two general-purpose user outputs. Two more control bits select loop mode, which parks all three pins at their inactive high level, and automatic RTS. With automatic RTS on, the receiver threshold logic can pull request-to-send inactive on its own.

The status side samples the active-low ring indicator pin through a synchronizer and reports its present condition. A trailing-edge event is recorded in a sticky bit. This event is the pin going from low back to high, which means the synchronized pin value rises. When the interrupt is enabled, the same event raises a modem-status interrupt request. Reading the status register clears both the sticky bit and the request. An event that lands in the same cycle as that read is kept.

The CPU reaches both registers through a simple single-cycle read/write port. `reg_sel` = 0 selects the control register and `reg_sel` = 1 selects the status register. Read data is combinational and shows the value before any clear that the read causes.

Top module: `mdm_hs_top`

## Requirements
- R1: With loop mode off, control bit 1 set drives `rts_n` low, bit 2 set drives `out1_n` low and bit 3 set drives `out2_n` low. The pin follows from the cycle after the write. A cleared bit returns its pin high. `rts_n` follows bit 1 only when it is not throttled (R4).
- R2: While `rst_n` is low, and after it is released, `rts_n`, `out1_n` and `out2_n` are high. The control register reads 0x00, status bit 2 is 0 and `msi_irq` is 0.
- R3: While control bit 4 (loop mode) is set, `rts_n`, `out1_n` and `out2_n` are all high whatever bits 1 to 3 hold.
- R4: While control bit 5 (automatic RTS) is set and `rx_thresh_hit` is 1, `rts_n` is high even with bit 1 set. With bit 5 clear, `rx_thresh_hit` has no effect on any pin.
- R5: Status bit 6 reads the complement of `ring_n`, two clock edges after `ring_n` changes. Status bits 0, 1, 3, 4, 5 and 7 always read 0.
- R6: A low-to-high transition of `ring_n` sets status bit 2 three edges later. The bit stays set until the status register is read. A high-to-low transition does not set it.
- R7: A low-to-high ring transition seen while `msi_en` is 1 raises `msi_irq`, which holds until the status register is read. With `msi_en` 0, the transition raises no request.
- R8: A status read (`rd_en` with `reg_sel` = 1) clears status bit 2 and `msi_irq` at the end of the read cycle. If a new ring transition is detected in that same cycle, bit 2 stays set.
- R9: Reads of the control register return exactly the last byte written to it. Writes with `reg_sel` = 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| rx_thresh_hit | input | 1 | Receiver threshold logic requests RTS inactive |
| msi_en | input | 1 | Modem-status interrupt enable |
| ring_n | input | 1 | Ring indicator pin, active low, asynchronous |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
Assertions check several rules on every cycle:
- the loop-mode and automatic-RTS overrides on the pins;
- that a detected ring rise sets the sticky bit and, when enabled, the interrupt;
- that a status read with no coincident rise clears both;
- that a control write is read back.

Some behaviour only the bench scenarios can show, because no single-cycle property captures it:
- the end-to-end latency from the ring pin through the synchronizer;
- the falling transition that must not set the bit;
- the read that coincides with a new rise;
- the reset values seen at the ports.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W     = 8;
  localparam int SYNC_LEN  = 2;
  // control register bit positions
  localparam int C_RTS     = 1;
  localparam int C_OUT1    = 2;
  localparam int C_OUT2    = 3;
  localparam int C_LOOP    = 4;
  localparam int C_AUTO    = 5;
  // status register bit positions
  localparam int S_TRAIL   = 2;
  localparam int S_RING    = 6;

  // active-low pin level from a control bit and an override
  function automatic logic pin_level(input logic ctl, input logic force_idle);
    return ~(ctl & ~force_idle);
  endfunction

  // status byte from the two live fields
  function automatic logic [REG_W-1:0] status_byte(input logic ring_now, input logic trail);
    logic [REG_W-1:0] v;
    v = '0;
    v[S_RING]  = ring_now;
    v[S_TRAIL] = trail;
    return v;
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             rx_thresh_hit,
  output logic [REG_W-1:0] ctl_q,
  output logic             rts_n,
  output logic             out1_n,
  output logic             out2_n
);
  logic loop_on;
  logic rts_throttle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= wdata;

  assign loop_on      = ctl_q[C_LOOP];
  assign rts_throttle = ctl_q[C_AUTO] & rx_thresh_hit;

  assign rts_n  = pin_level(ctl_q[C_RTS], loop_on | rts_throttle);
  assign out1_n = pin_level(ctl_q[C_OUT1], loop_on);
  assign out2_n = pin_level(ctl_q[C_OUT2], loop_on);

  assert_loop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (rts_n && out1_n && out2_n));

  assert_auto_rts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[C_AUTO] && rx_thresh_hit) |-> rts_n);

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q == $past(wdata)));
endmodule

// File: rtl/mdm_ring_det.sv
module mdm_ring_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_level,   // synchronized pin level, high = idle
  input  logic msi_en,
  input  logic st_rd,
  output logic ring_rise,
  output logic trail_q,
  output logic irq_q
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_d <= 1'b1;
    else        level_d <= ring_level;

  assign ring_rise = ring_level & ~level_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trail_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ring_rise)  trail_q <= 1'b1;
      else if (st_rd) trail_q <= 1'b0;
      if (ring_rise && msi_en) irq_q <= 1'b1;
      else if (st_rd)          irq_q <= 1'b0;
    end

  assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ring_rise |=> trail_q);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_rise && msi_en) |=> irq_q);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !ring_rise) |=> (!trail_q && !irq_q));
endmodule

// File: rtl/mdm_hs_top.sv
module mdm_hs_top
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             rx_thresh_hit,
  input  logic             msi_en,
  input  logic             ring_n,
  output logic             rts_n,
  output logic             out1_n,
  output logic             out2_n,
  output logic             msi_irq
);
  logic [REG_W-1:0] ctl_q;
  logic             ring_lvl;
  logic             ring_rise;
  logic             trail_q;
  logic             ctl_wr;
  logic             st_rd;

  assign ctl_wr = wr_en & ~reg_sel;
  assign st_rd  = rd_en & reg_sel;

  mdm_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(wdata),
    .rx_thresh_hit(rx_thresh_hit), .ctl_q(ctl_q),
    .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  mdm_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ring_n), .q_sync(ring_lvl)
  );

  mdm_ring_det u_ring (
    .clk(clk), .rst_n(rst_n), .ring_level(ring_lvl), .msi_en(msi_en),
    .st_rd(st_rd), .ring_rise(ring_rise), .trail_q(trail_q), .irq_q(msi_irq)
  );

  assign rdata = reg_sel ? status_byte(~ring_lvl, trail_q) : ctl_q;

  assert_reset_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == '0) |-> (rts_n && out1_n && out2_n));

  assert_status_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> ((rdata & ~(8'h44)) == '0));
endmodule

// File: tb/test_mdm_hs_top.sv
`timescale 1ns/1ps
module test_mdm_hs_top;
  logic clk = 0;
  logic rst_n = 0;
  logic reg_sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic rx_thresh_hit = 0, msi_en = 0, ring_n = 1;
  logic rts_n, out1_n, out2_n, msi_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] shadow = 0;

  always #4 clk = ~clk;

  mdm_hs_top i_mdm_hs_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_thresh_hit(rx_thresh_hit), .msi_en(msi_en),
    .ring_n(ring_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .msi_irq(msi_irq)
  );

  // expected pins {rts_n,out1_n,out2_n}, restated from R1/R3/R4
  function automatic logic [2:0] exp_pins(input logic [7:0] c, input logic hit);
    logic idle, rts_on;
    idle   = c[4];
    rts_on = c[1] && !idle && !(c[5] && hit);
    return {!rts_on, !(c[2] && !idle), !(c[3] && !idle)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v, input logic sel = 0);
    @(negedge clk);
    reg_sel = sel; wr_en = 1; wdata = v;
    @(negedge clk);
    wr_en = 0;
    if (!sel) shadow = v;
  endtask

  // read; value sampled mid-cycle, before the clearing edge
  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel; rd_en = 1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic ring_to(input logic lvl);
    @(negedge clk);
    ring_n = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    #2;
    chk("R2 pins in reset", {rts_n, out1_n, out2_n}, 3'b111);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R2 pins after reset", {rts_n, out1_n, out2_n}, 3'b111);
    chk("R2 irq after reset", msi_irq, 0);
    rd(0, v); chk("R2 control reads zero", v, 8'h00);
    rd(1, v); chk("R2 status bit2 clear", v[2], 0);

    wr_ctl(8'h0E);
    chk("R1 all pins active", {rts_n, out1_n, out2_n}, 3'b000);
    wr_ctl(8'h04);
    chk("R1 only out1 active", {rts_n, out1_n, out2_n}, 3'b101);
    wr_ctl(8'h1E);
    chk("R3 loop forces idle", {rts_n, out1_n, out2_n}, 3'b111);
    wr_ctl(8'h22); rx_thresh_hit = 1; #1;
    chk("R4 auto rts throttled", rts_n, 1);
    wr_ctl(8'h02); #1;
    chk("R4 hit ignored without auto", {rts_n, out1_n, out2_n}, 3'b011);
    rx_thresh_hit = 0;
    wr_ctl(8'hA5, 1);
    rd(0, v); chk("R9 status write ignored", v, 8'h02);

    // random control traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rx_thresh_hit = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) begin
        reg_sel = 0; wr_en = 1; wdata = 8'($urandom);
        @(negedge clk); wr_en = 0; shadow = wdata;
      end
      #1 chk("R1 R3 R4 random pins", {rts_n, out1_n, out2_n}, exp_pins(shadow, rx_thresh_hit));
      if ((i % 37) == 0) begin
        rd(0, v); chk("R9 random readback", v, shadow);
      end
    end
    rx_thresh_hit = 0;

    // ring indicator
    msi_en = 0;
    ring_to(0);
    rd(1, v);
    chk("R5 ring active", v, 8'h40);
    chk("R6 falling does not set", v[2], 0);
    ring_to(1);
    rd(1, v);
    chk("R6 rise sets bit2 R5 idle", v, 8'h04);
    chk("R7 no irq when disabled", msi_irq, 0);
    rd(1, v); chk("R8 read cleared bit2", v[2], 0);

    msi_en = 1;
    ring_to(0);
    ring_to(1);
    chk("R7 irq raised", msi_irq, 1);
    repeat (5) @(negedge clk);
    chk("R7 irq held", msi_irq, 1);
    rd(1, v);
    chk("R8 irq cleared by read", msi_irq, 0);
    rd(1, v); chk("R8 bit2 cleared by read", v[2], 0);

    // read coinciding with a detected rise
    ring_to(0);
    @(negedge clk) ring_n = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_sel = 1; rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R8 coincident edge keeps irq", msi_irq, 1);
    rd(1, v); chk("R8 coincident edge keeps bit2", v[2], 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule